// File: doc/BRIEF.md
# Configurable Registered I/O Cell

This block sits between the internal logic array and a pad driver. It carries one outbound path (array to pad) and one inbound path (pad to array). Each path holds a single D-type storage register, and both registers run from one dedicated I/O clock. Static configuration inputs set each path to registered or combinational. A path in combinational mode passes its data straight through. A path in registered mode captures data on the rising clock edge when that path's own data-enable input is high.

One shared, active-high asynchronous initialisation network feeds both registers. A static per-cell selection decides what the network does: with the selection high it forces the registers to all ones, and with it low it forces them to all zeros. This takes effect at once and overrides both the clock and the enables. The selection is expected to stay fixed during operation. The pad driver, tristate control and routing fabric are outside this block.

Top module: `io_cell_top`

## Requirements
- R1: With the outbound path registered (`out_comb` = 0), the outbound register loads `core_out_d` on a rising edge of `io_clk` when `out_en` = 1, and `pad_out` shows that value after the edge.
- R2: With the inbound path registered (`in_comb` = 0), the inbound register loads `pad_in_d` on a rising edge of `io_clk` when `in_en` = 1, and `core_in` shows that value after the edge.
- R3: A register whose enable is 0 at a rising `io_clk` edge keeps its previous value. Each enable acts on its own path only.
- R4: With `init_to_one` = 1, raising `async_init` drives every registered-path output bit to 1 at once, with no clock edge needed.
- R5: With `init_to_one` = 0, raising `async_init` drives every registered-path output bit to 0 at once, with no clock edge needed.
- R6: While `async_init` = 1, clock edges with the enable high do not load data. After release, the register holds its forced value until the next enabled edge.
- R7: With `out_comb` = 1, `pad_out` equals `core_out_d` combinationally, whatever the clock, enable or `async_init` state.
- R8: With `in_comb` = 1, `core_in` equals `pad_in_d` combinationally, whatever the clock, enable or `async_init` state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| io_clk | input | 1 | Dedicated I/O clock, rising edge |
| async_init | input | 1 | Shared asynchronous init network, active high |
| init_to_one | input | 1 | Static: 1 = init forces ones, 0 = init forces zeros |
| out_comb | input | 1 | Static: 1 = outbound path bypasses its register |
| in_comb | input | 1 | Static: 1 = inbound path bypasses its register |
| out_en | input | 1 | Outbound register data enable |
| in_en | input | 1 | Inbound register data enable |
| core_out_d | input | WIDTH | Data from the array toward the pad |
| pad_out | output | WIDTH | Data toward the pad driver |
| pad_in_d | input | WIDTH | Data from the pad driver |
| core_in | output | WIDTH | Data toward the array |

## Verification
A wrong register state shows up on a registered path's output within the same clock period. An init that fails to act shows up within a fraction of a cycle, because the bench samples between the mid-cycle rise of `async_init` and the next clock edge. A dropped or spurious enable changes the output one edge later, and the bench models each register separately. Bypass faults show up at the very next sample, even while `async_init` is active.

// File: rtl/io_cell_pkg.sv
`timescale 1ns/1ps
package io_cell_pkg;
  // Index of each path inside the cell's path arrays.
  localparam int unsigned PATH_OUT = 0;
  localparam int unsigned PATH_IN  = 1;
  localparam int unsigned NPATH    = 2;

  // What a storage register does on a clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_FORCE = 2'd2
  } reg_action_e;

  // Decide the action for one register from the init and enable inputs.
  function automatic reg_action_e pick_action(input logic init_on, input logic en);
    if (init_on)  return ACT_FORCE;
    else if (en)  return ACT_LOAD;
    else          return ACT_HOLD;
  endfunction
endpackage

// File: rtl/io_cell_regpath.sv
`timescale 1ns/1ps
module io_cell_regpath
  import io_cell_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             init_on,
  input  logic             init_ones,
  input  logic             comb_mode,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] y,
  output logic             ev_load,
  output logic             ev_force
);
  localparam logic [WIDTH-1:0] ALL_ONES  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL_ZEROS = {WIDTH{1'b0}};

  // Value the shared init network imposes on this register.
  function automatic logic [WIDTH-1:0] init_word(input logic ones);
    return ones ? ALL_ONES : ALL_ZEROS;
  endfunction

  reg_action_e      act;
  logic [WIDTH-1:0] q;

  always_comb act = pick_action(init_on, en);

  assign ev_load  = (act == ACT_LOAD);
  assign ev_force = (act == ACT_FORCE);

  // The init network has priority over the clock and the enable.
  always_ff @(posedge clk or posedge init_on) begin
    if (init_on)    q <= init_word(init_ones);
    else if (en)    q <= d;
  end

  assign y = comb_mode ? d : q;
endmodule

// File: rtl/io_cell_top.sv
`timescale 1ns/1ps
module io_cell_top
  import io_cell_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             io_clk,
  input  logic             async_init,
  input  logic             init_to_one,
  input  logic             out_comb,
  input  logic             in_comb,
  input  logic             out_en,
  input  logic             in_en,
  input  logic [WIDTH-1:0] core_out_d,
  output logic [WIDTH-1:0] pad_out,
  input  logic [WIDTH-1:0] pad_in_d,
  output logic [WIDTH-1:0] core_in
);
  logic [NPATH-1:0]            path_comb;
  logic [NPATH-1:0]            path_en;
  logic [NPATH-1:0][WIDTH-1:0] path_d;
  logic [NPATH-1:0][WIDTH-1:0] path_y;
  logic [NPATH-1:0]            path_load;
  logic [NPATH-1:0]            path_force;

  assign path_comb[PATH_OUT] = out_comb;
  assign path_comb[PATH_IN]  = in_comb;
  assign path_en[PATH_OUT]   = out_en;
  assign path_en[PATH_IN]    = in_en;
  assign path_d[PATH_OUT]    = core_out_d;
  assign path_d[PATH_IN]     = pad_in_d;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    io_cell_regpath #(.WIDTH(WIDTH)) u_path (
      .clk       (io_clk),
      .init_on   (async_init),
      .init_ones (init_to_one),
      .comb_mode (path_comb[p]),
      .en        (path_en[p]),
      .d         (path_d[p]),
      .y         (path_y[p]),
      .ev_load   (path_load[p]),
      .ev_force  (path_force[p])
    );
  end

  // Named event wires kept for the bound checker.
  logic out_load_ev, in_load_ev, init_force_ev;
  assign out_load_ev   = path_load[PATH_OUT];
  assign in_load_ev    = path_load[PATH_IN];
  assign init_force_ev = path_force[PATH_OUT] & path_force[PATH_IN];

  assign pad_out = path_y[PATH_OUT];
  assign core_in = path_y[PATH_IN];
endmodule

// File: rtl/io_cell_chk.sv
`timescale 1ns/1ps
module io_cell_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             io_clk,
  input logic             async_init,
  input logic             init_to_one,
  input logic             out_comb,
  input logic             in_comb,
  input logic             out_en,
  input logic             in_en,
  input logic [WIDTH-1:0] core_out_d,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_in_d,
  input logic [WIDTH-1:0] core_in,
  input logic             out_load_ev,
  input logic             in_load_ev,
  input logic             init_force_ev
);
  logic [WIDTH-1:0] forced_word;
  assign forced_word = init_to_one ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  // R1: an enabled edge loads the outbound data
  a_r1_out_capture: assert property (@(posedge io_clk) disable iff (async_init)
    (!out_comb && out_load_ev) |=> (out_comb || pad_out == $past(core_out_d)));

  // R2: an enabled edge loads the inbound data
  a_r2_in_capture: assert property (@(posedge io_clk) disable iff (async_init)
    (!in_comb && in_load_ev) |=> (in_comb || core_in == $past(pad_in_d)));

  // R3: a disabled edge leaves each register unchanged
  a_r3_out_hold: assert property (@(posedge io_clk) disable iff (async_init)
    (!out_comb && !out_en) |=> (out_comb || $stable(pad_out)));
  a_r3_in_hold: assert property (@(posedge io_clk) disable iff (async_init)
    (!in_comb && !in_en) |=> (in_comb || $stable(core_in)));

  // R7, R8: bypassed paths follow their inputs, even during init
  a_r7_out_bypass: assert property (@(posedge io_clk) disable iff (1'b0)
    out_comb |-> pad_out == core_out_d);
  a_r8_in_bypass: assert property (@(posedge io_clk) disable iff (1'b0)
    in_comb |-> core_in == pad_in_d);

  // R4, R5, R6: registered outputs show the forced word while init is high
  always @(negedge io_clk) begin
    if (async_init && !out_comb)
      a_r6_out_forced: assert (pad_out == forced_word && init_force_ev);
    if (async_init && !in_comb)
      a_r6_in_forced: assert (core_in == forced_word);
  end
endmodule

bind io_cell_top io_cell_chk #(.WIDTH(WIDTH)) u_chk (
  .io_clk        (io_clk),
  .async_init    (async_init),
  .init_to_one   (init_to_one),
  .out_comb      (out_comb),
  .in_comb       (in_comb),
  .out_en        (out_en),
  .in_en         (in_en),
  .core_out_d    (core_out_d),
  .pad_out       (pad_out),
  .pad_in_d      (pad_in_d),
  .core_in       (core_in),
  .out_load_ev   (out_load_ev),
  .in_load_ev    (in_load_ev),
  .init_force_ev (init_force_ev)
);

// File: tb/tb_io_cell_top.sv
`timescale 1ns/1ps
module tb_io_cell_top;
  localparam int unsigned W = 4;

  logic         io_clk = 1'b0;
  logic         async_init = 1'b1;
  logic         init_to_one = 1'b0;
  logic         out_comb = 1'b0;
  logic         in_comb = 1'b0;
  logic         out_en = 1'b0;
  logic         in_en = 1'b0;
  logic [W-1:0] core_out_d = '0;
  logic [W-1:0] pad_in_d = '0;
  logic [W-1:0] pad_out;
  logic [W-1:0] core_in;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] m_out = '0;
  logic [W-1:0] m_in = '0;
  bit done = 0;

  always #2 io_clk = ~io_clk;   // 250 MHz

  io_cell_top #(.WIDTH(W)) dut (.*);

  function automatic logic [W-1:0] forced(input logic ones);
    return ones ? '1 : '0;
  endfunction

  function automatic logic [W-1:0] want(input logic comb, input logic [W-1:0] d,
                                        input logic [W-1:0] m);
    return comb ? d : m;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string ro, input string ri);
    chk(ro, pad_out, want(out_comb, core_out_d, m_out));
    chk(ri, core_in, want(in_comb, pad_in_d, m_in));
  endtask

  // Bench model of both registers, applied right after a rising edge.
  task automatic edge_update();
    @(posedge io_clk);
    if (async_init) begin
      m_out = forced(init_to_one);
      m_in  = forced(init_to_one);
    end else begin
      if (out_en) m_out = core_out_d;
      if (in_en)  m_in  = pad_in_d;
    end
  endtask

  // One randomized cycle, starting and ending at a falling edge.
  task automatic rand_cycle(input bit allow_init);
    async_init = 1'b0;
    out_en     = ($urandom % 4) != 0;
    in_en      = ($urandom % 3) != 0;
    core_out_d = W'($urandom);
    pad_in_d   = W'($urandom);
    if (($urandom % 16) == 0) out_comb = ~out_comb;
    if (($urandom % 16) == 0) in_comb  = ~in_comb;
    #1;
    check_outs("R1/R3/R7", "R2/R3/R8");
    if (allow_init && ($urandom % 10) == 0) begin
      #0.5 async_init = 1'b1;
      #0.2;
      if (init_to_one) begin
        chk("R4", pad_out, want(out_comb, core_out_d, forced(1'b1)));
        chk("R4", core_in, want(in_comb, pad_in_d, forced(1'b1)));
      end else begin
        chk("R5", pad_out, want(out_comb, core_out_d, forced(1'b0)));
        chk("R5", core_in, want(in_comb, pad_in_d, forced(1'b0)));
      end
      m_out = forced(init_to_one);
      m_in  = forced(init_to_one);
    end
    edge_update();
    @(negedge io_clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // Reset state: init held high in clear mode, before any clock edge
    #1;
    chk("R5", pad_out, '0);
    chk("R5", core_in, '0);
    @(negedge io_clk);
    async_init = 1'b0;

    // Directed R1/R2: load
    out_en = 1; in_en = 1; core_out_d = 4'hA; pad_in_d = 4'h5;
    edge_update(); #1;
    chk("R1", pad_out, 4'hA);
    chk("R2", core_in, 4'h5);
    @(negedge io_clk);

    // Directed R3: only the outbound enable low
    out_en = 0; in_en = 1; core_out_d = 4'h3; pad_in_d = 4'hC;
    edge_update(); #1;
    chk("R3", pad_out, 4'hA);
    chk("R2", core_in, 4'hC);
    @(negedge io_clk);

    // Directed R6: preset mode, enables high across an edge during init
    init_to_one = 1; out_en = 1; in_en = 1; core_out_d = 4'h1; pad_in_d = 4'h2;
    #1 async_init = 1;
    #0.3;
    chk("R4", pad_out, 4'hF);
    chk("R4", core_in, 4'hF);
    m_out = '1; m_in = '1;
    edge_update(); #1;
    chk("R6", pad_out, 4'hF);
    chk("R6", core_in, 4'hF);
    @(negedge io_clk);
    async_init = 0; out_en = 0; in_en = 0;
    #1;
    chk("R6", pad_out, 4'hF);
    chk("R6", core_in, 4'hF);
    @(negedge io_clk);

    // Directed R7/R8: bypass during init in clear mode
    init_to_one = 0; out_comb = 1; in_comb = 1;
    core_out_d = 4'h9; pad_in_d = 4'h6; async_init = 1;
    #1;
    chk("R7", pad_out, 4'h9);
    chk("R8", core_in, 4'h6);
    m_out = '0; m_in = '0;
    out_comb = 0; #0.2;
    chk("R5", pad_out, 4'h0);
    out_comb = 1;
    edge_update();
    @(negedge io_clk);
    async_init = 0;

    // Random phases in both init modes
    for (int ph = 0; ph < 2; ph++) begin
      init_to_one = ph[0];
      for (int i = 0; i < 400; i++) rand_cycle(1'b1);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge io_clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule